// File: doc/BRIEF.md
# Floating-Point Control and Exception Register

This block is the 32-bit control and status word that sits beside a floating-point arithmetic unit. It holds six per-class exception enables, six sticky exception flags, an 8-bit data-exception code, and two 3-bit rounding-mode selectors: one for decimal arithmetic and one for binary arithmetic. The two rounding modes drive the arithmetic unit directly.

Each cycle the arithmetic unit may present a set of exception indications. The six classes are invalid operation, divide by zero, overflow, underflow, inexact and quantum. For each class that occurs, the enable bit picks the outcome. If the class is disabled, the block records it in the sticky flag. If the class is enabled, the block asks for a trap instead. When a trap is asked for, the block forms a one-hot exception code for the most important enabled class. It writes that code into the register only while a separate capture-enable input is high.

Software reads the whole word at any time and replaces it with a single write. Bit positions in the word are fixed, because code outside the block decodes them. Bit 0 of the word is its most significant bit, so that bit is `rd_data[31]`.

Top module: `fpcr_ctrl`

## Requirements
- R1: After reset, every field reads zero except the decimal mode field and the binary mode field. These two hold the reset values given by the parameters `RST_DRM` and `RST_BRM`.
- R2: A write sets the register from `wr_data`, and reads then return the following layout:
  - `[31:26]` enables
  - `[23:18]` flags
  - `[15:8]` exception code
  - `[6:4]` decimal mode
  - `[2:0]` binary mode

  Bits `[25:24]`, `[17:16]`, `[7]` and `[3]` always read zero.
- R3: `dfp_rmode` always equals register bits `[6:4]`, and `bfp_rmode` always equals bits `[2:0]`.
- R4: The exception input uses this encoding: `exc_in[5]` invalid, `[4]` divide by zero, `[3]` overflow, `[2]` underflow, `[1]` inexact, `[0]` quantum. Class i is enabled by register bit `[26+i]` and flagged in bit `[18+i]`. A class that occurs while its enable is 0 sets its flag at the next clock edge and asks for no trap.
- R5: A class that occurs while its enable is 1 raises `trap_req` in the same cycle and leaves its flag unchanged.
- R6: A flag that is set stays set until a software write changes it.
- R7: When `trap_req` is high, `trap_dxc` is one-hot for the highest-priority enabled class that occurred. The priority order, from highest, is invalid, divide by zero, overflow, underflow, inexact, quantum. The matching codes are 0x80, 0x40, 0x20, 0x10, 0x08 and 0x04.
- R8: The exception code field takes the value of `trap_dxc` at the clock edge that ends a trap cycle, but only when `afp_en` is 1. If `afp_en` is 0, the field is left unchanged.
- R9: A write in the same cycle as exceptions wins for the register contents. `trap_req` and `trap_dxc` are still reported in that cycle.
- R10: While `exc_valid` is 0, `exc_in` has no effect on the register or on `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current register value |
| exc_valid | input | 1 | Exception indications are valid this cycle |
| exc_in | input | 6 | Exception classes raised by the arithmetic unit |
| afp_en | input | 1 | Capture enable for the exception code on a trap |
| trap_req | output | 1 | An enabled exception occurred this cycle |
| trap_dxc | output | 8 | One-hot code of the highest-priority trapping class |
| dfp_rmode | output | 3 | Decimal rounding mode |
| bfp_rmode | output | 3 | Binary rounding mode |

## Verification
The bench builds the block with non-zero reset rounding modes, `RST_DRM` = 2 and `RST_BRM` = 5. This shows that both mode fields come out of reset from their own parameters and land in the right bit positions, which an all-zero default would hide. With these values, a swapped or shifted mode field is visible right after reset. So is one that ignores its parameter. Random cycles then mix writes, multi-class exception bursts and capture-enable changes, so that priority collisions and write-versus-exception races come up repeatedly.

// File: rtl/fpcr_pkg.sv
package fpcr_pkg;

    localparam int EXC_N    = 6;
    localparam int CODE_W   = 8;
    localparam int RM_W     = 3;
    localparam int REG_W    = 32;

    localparam int MASK_LSB = 26;
    localparam int FLAG_LSB = 18;
    localparam int DXC_LSB  = 8;
    localparam int DRM_LSB  = 4;
    localparam int BRM_LSB  = 0;

    // class i maps to code bit CODE_OFS+i
    localparam int CODE_OFS = CODE_W - EXC_N;

    localparam logic [REG_W-1:0] RSV_MASK = 32'h0303_0088;

    typedef logic [EXC_N-1:0]  exc_vec_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [RM_W-1:0]   rmode_t;

    typedef struct packed {
        exc_vec_t mask;
        exc_vec_t flag;
        code_t    dxc;
        rmode_t   drm;
        rmode_t   brm;
    } fpcr_t;

    function automatic logic [REG_W-1:0] pack_reg(input fpcr_t r);
        logic [REG_W-1:0] w;
        w = '0;
        w[MASK_LSB +: EXC_N]  = r.mask;
        w[FLAG_LSB +: EXC_N]  = r.flag;
        w[DXC_LSB  +: CODE_W] = r.dxc;
        w[DRM_LSB  +: RM_W]   = r.drm;
        w[BRM_LSB  +: RM_W]   = r.brm;
        return w;
    endfunction

    function automatic fpcr_t unpack_reg(input logic [REG_W-1:0] w);
        fpcr_t r;
        r.mask = w[MASK_LSB +: EXC_N];
        r.flag = w[FLAG_LSB +: EXC_N];
        r.dxc  = w[DXC_LSB  +: CODE_W];
        r.drm  = w[DRM_LSB  +: RM_W];
        r.brm  = w[BRM_LSB  +: RM_W];
        return r;
    endfunction

    function automatic code_t class_code(input int idx);
        return code_t'(1) << (idx + CODE_OFS);
    endfunction

endpackage

// File: rtl/fpcr_exc_route.sv
module fpcr_exc_route
    import fpcr_pkg::*;
(
    input  logic     exc_valid,
    input  exc_vec_t exc_in,
    input  exc_vec_t mask,
    output exc_vec_t set_flag,
    output exc_vec_t trap_hit
);

    for (genvar i = 0; i < EXC_N; i++) begin : g_class
        assign set_flag[i] = exc_valid & exc_in[i] & ~mask[i];
        assign trap_hit[i] = exc_valid & exc_in[i] &  mask[i];
    end

endmodule

// File: rtl/fpcr_trap_prio.sv
module fpcr_trap_prio
    import fpcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  exc_vec_t trap_hit,
    output logic     trap_any,
    output code_t    code
);

    // ascending scan: higher index (higher priority) overwrites lower
    always_comb begin
        code = '0;
        for (int i = 0; i < EXC_N; i++) begin
            if (trap_hit[i]) code = class_code(i);
        end
    end

    assign trap_any = |trap_hit;

    // R7
    trap_code_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        trap_any |-> ($countones(code) == 1));

    // R7
    trap_code_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_any |-> (code == '0));

endmodule

// File: rtl/fpcr_ctrl.sv
module fpcr_ctrl
    import fpcr_pkg::*;
#(
    parameter logic [2:0] RST_DRM = 3'd0,
    parameter logic [2:0] RST_BRM = 3'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        exc_valid,
    input  logic [5:0]  exc_in,
    input  logic        afp_en,
    output logic        trap_req,
    output logic [7:0]  trap_dxc,
    output logic [2:0]  dfp_rmode,
    output logic [2:0]  bfp_rmode
);

    localparam fpcr_t RST_VAL = '{mask: '0, flag: '0, dxc: '0,
                                  drm: RST_DRM, brm: RST_BRM};

    fpcr_t    cur_q;
    fpcr_t    nxt;
    exc_vec_t set_flag;
    exc_vec_t trap_hit;
    logic     trap_any;
    code_t    code;

    fpcr_exc_route u_route (
        .exc_valid (exc_valid),
        .exc_in    (exc_in),
        .mask      (cur_q.mask),
        .set_flag  (set_flag),
        .trap_hit  (trap_hit)
    );

    fpcr_trap_prio u_prio (
        .clk      (clk),
        .rst      (rst),
        .trap_hit (trap_hit),
        .trap_any (trap_any),
        .code     (code)
    );

    always_comb begin
        nxt      = cur_q;
        nxt.flag = cur_q.flag | set_flag;
        if (trap_any && afp_en) nxt.dxc = code;
        if (wr_en) nxt = unpack_reg(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= RST_VAL;
        else     cur_q <= nxt;
    end

    assign rd_data   = pack_reg(cur_q);
    assign dfp_rmode = cur_q.drm;
    assign bfp_rmode = cur_q.brm;
    assign trap_req  = trap_any;
    assign trap_dxc  = code;

    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & ~RSV_MASK)));

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && exc_valid) |=>
        ((cur_q.flag & $past(exc_in & ~cur_q.mask)) == $past(exc_in & ~cur_q.mask)));

    // R5
    masked_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && exc_valid) |=>
        (((cur_q.flag ^ $past(cur_q.flag)) & $past(cur_q.mask)) == '0));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((cur_q.flag & $past(cur_q.flag)) == $past(cur_q.flag)));

    // R8
    dxc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !(trap_req && afp_en)) |=> $stable(cur_q.dxc));

    // R10
    idle_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> !trap_req);

endmodule

// File: tb/fpcr_ctrl_bench.sv
`timescale 1ns/1ps
module fpcr_ctrl_bench;

    localparam logic [2:0] P_DRM = 3'd2;
    localparam logic [2:0] P_BRM = 3'd5;
    localparam logic [31:0] RSV = 32'h0303_0088;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        exc_valid;
    logic [5:0]  exc_in;
    logic        afp_en;
    logic        trap_req;
    logic [7:0]  trap_dxc;
    logic [2:0]  dfp_rmode;
    logic [2:0]  bfp_rmode;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m;

    always #2.5 clk = ~clk;

    fpcr_ctrl #(.RST_DRM(P_DRM), .RST_BRM(P_BRM)) u_fpcr_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .exc_valid(exc_valid), .exc_in(exc_in),
        .afp_en(afp_en), .trap_req(trap_req), .trap_dxc(trap_dxc),
        .dfp_rmode(dfp_rmode), .bfp_rmode(bfp_rmode)
    );

    function automatic logic [5:0] f_hits(logic [31:0] r, logic ev, logic [5:0] ex);
        return ev ? (ex & r[31:26]) : 6'd0;
    endfunction

    function automatic logic [7:0] f_code(logic [5:0] hits);
        for (int i = 5; i >= 0; i--) if (hits[i]) return 8'h04 << i;
        return 8'h00;
    endfunction

    function automatic logic [31:0] f_next(logic [31:0] r, logic we, logic [31:0] wd,
                                           logic ev, logic [5:0] ex, logic afp);
        logic [31:0] n;
        logic [5:0]  hits;
        if (we) return wd & ~RSV;
        n = r;
        hits = f_hits(r, ev, ex);
        if (ev) n[23:18] = r[23:18] | (ex & ~r[31:26]);
        if (hits != 0 && afp) n[15:8] = f_code(hits);
        return n;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic we, logic [31:0] wd, logic ev,
                        logic [5:0] ex, logic afp);
        logic [5:0]  hits;
        logic [31:0] mn;
        wr_en = we; wr_data = wd; exc_valid = ev; exc_in = ex; afp_en = afp;
        #1;
        hits = f_hits(m, ev, ex);
        chk({tag, " R5 trap_req"}, 32'(trap_req), 32'(hits != 0));
        chk({tag, " R7 trap_dxc"}, 32'(trap_dxc), 32'(f_code(hits)));
        mn = f_next(m, we, wd, ev, ex, afp);
        @(negedge clk);
        m = mn;
        chk({tag, " rd_data"}, rd_data, m);
        chk({tag, " R3 modes"}, {26'd0, dfp_rmode, bfp_rmode}, {26'd0, m[6:4], m[2:0]});
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst = 1'b1; wr_en = 0; wr_data = 0; exc_valid = 0; exc_in = 0; afp_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m = {25'd0, P_DRM, 1'b0, P_BRM};
        // R1 reset state
        chk("R1 reset rd_data", rd_data, m);
        chk("R1 reset modes", {26'd0, dfp_rmode, bfp_rmode}, {26'd0, P_DRM, P_BRM});
        // R2 write all ones, reserved bits read zero
        step("R2 write ones", 1, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R2 layout", rd_data, 32'hFCFC_FF77);
        // R3 mode fields
        step("R3 modes", 1, 32'h0000_0061, 0, 0, 0);
        chk("R3 dfp", 32'(dfp_rmode), 32'd6);
        chk("R3 bfp", 32'(bfp_rmode), 32'd1);
        // R4 all disabled, all classes occur
        step("R4 all flag", 0, 0, 1, 6'h3F, 1);
        chk("R4 flags set", 32'(rd_data[23:18]), 32'h3F);
        // R6 sticky over idle cycles
        repeat (3) step("R6 idle", 0, 0, 0, 0, 0);
        chk("R6 flags kept", 32'(rd_data[23:18]), 32'h3F);
        // R10 exc_valid low ignores inputs
        step("R2 enables", 1, 32'hFC00_0000, 0, 0, 0);
        step("R10 ignored", 0, 0, 0, 6'h3F, 1);
        chk("R10 no change", rd_data, 32'hFC00_0000);
        // R5 R7 R8 all enabled, all occur: invalid wins
        step("R7 all trap", 0, 0, 1, 6'h3F, 1);
        chk("R8 dxc loaded", 32'(rd_data[15:8]), 32'h80);
        chk("R5 flags untouched", 32'(rd_data[23:18]), 32'h0);
        // R7 lowest class only
        step("R7 quantum", 0, 0, 1, 6'h01, 1);
        chk("R7 quantum code", 32'(rd_data[15:8]), 32'h04);
        // R8 capture disabled
        step("R8 no capture", 0, 0, 1, 6'h08, 0);
        chk("R8 dxc held", 32'(rd_data[15:8]), 32'h04);
        // mixed: overflow enabled only, overflow+inexact occur
        step("R2 ovf only", 1, 32'h2000_0000, 0, 0, 0);
        step("R4 mixed", 0, 0, 1, 6'h0A, 1);
        chk("R4 inexact flag", 32'(rd_data[23:18]), 32'h02);
        chk("R7 ovf code", 32'(rd_data[15:8]), 32'h20);
        // R9 write racing exceptions
        step("R9 write wins", 1, 32'h2000_0000, 1, 6'h3F, 1);
        chk("R9 write value", rd_data, 32'h2000_0000);
        // R6 write clears flags
        step("R6 flags up", 0, 0, 1, 6'h10, 1);
        step("R6 clear", 1, 32'h0, 0, 0, 0);
        chk("R6 cleared", 32'(rd_data[23:18]), 32'h0);
        // random phase
        for (int k = 0; k < 400; k++) begin
            logic we;
            we = ($urandom % 6) == 0;
            step("R4/R5/R7/R8/R9 random", we, $urandom, ($urandom % 4) != 0,
                 6'($urandom), 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule